// File: doc/BRIEF.md
# Flash Multi-Block Erase Sequencer

This block drives the erase of a flash array organised as a low/mid address space and a high address space, plus one separate shadow row. Software reaches it through a small register port. It holds two lock registers for the low/mid space, one lock register for the high space, and two block-select registers. A control register carries an erase-mode flag, a high-voltage-enable flag that launches the erase, a shadow-row flag and a completion flag.

The erase starts when the erase-mode flag is set and the enable flag then rises. The sequencer works out the eligible blocks, which are the selected blocks that are not locked. It erases them one at a time, lowest index first. Each block takes a fixed number of cycles, and at its end every word of the block becomes all ones. In shadow mode only the shadow row is erased, and the select and lock registers play no part.

Clearing the enable flag during a run aborts the erase. The block in progress is filled with a fixed non-erased pattern and marked dirty. A later successful erase of that block clears the dirty mark. The array is a register-file model with its own read port.

Top module: `flash_erase_seq`

Register map (`reg_addr`): 0 control (bit0 erase mode, bit1 enable, bit2 shadow, bit3 done, read-only), 1 low/mid lock A, 2 low/mid lock B, 3 high lock, 4 low/mid select, 5 high select, 6 dirty flags (read-only). Block index i below NUM_LM is low/mid bit i. Index NUM_LM+j is high bit j. Index NUM_LM+NUM_HI is the shadow row.

## Requirements
- R1: After reset all registers read 0, every array word reads 0 and no block is dirty.
- R2: A completed erase sets every word of each eligible block to all ones and leaves every other block unchanged.
- R3: A selected block whose bit is set in lock A or lock B (low/mid), or in the high lock, is not erased.
- R4: Eligible blocks are erased in ascending index order, ERASE_CYC cycles each; done reads 1 exactly k*ERASE_CYC cycles after the launching write, where k is the number of eligible blocks.
- R5: The enable bit can only be set while erase mode is already 1. Select writes made while erase mode is 0 are ignored.
- R6: With the shadow bit set in the launching write, only the shadow row is erased, whatever the select and lock registers hold.
- R7: Writing enable=0 during a run fills the block in progress with ABORT_WORD, marks it dirty, leaves later blocks untouched and makes done read 1 in the next cycle.
- R8: A successful erase of a dirty block clears its dirty flag.
- R9: While a run is active, lock and select writes are ignored, and a control write changes only the enable bit.
- R10: A launch with no eligible block makes done read 1 in the cycle after the launching write.
- R11: Writing erase mode to 0 clears done and both select registers.
- R12: The three lock registers read back the value written while no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| rd_blk | input | IDX_W | Array read block index |
| rd_word | input | WA_W | Array read word index |
| rd_data | output | DW | Array read data, combinational |

## Verification
A wrong sequencer state shows up as a done flag that arrives a multiple of ERASE_CYC cycles too early or too late. It can also appear as a block that stays at zero or ends up all ones against the lock and select settings. Ordering errors become visible through aborts at chosen cycles, because the pattern-filled block identifies which block was active when the abort write landed. A corrupted lock or select register during a run appears as a changed read-back value within a few cycles. Eligibility errors surface as array contents after done.

// File: rtl/fes_pkg.sv
// Package: register addresses, control bit positions and sequencer state
// shared by the flash erase sequencer modules.
package fes_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_LOCKA = 3'd1,
        RA_LOCKB = 3'd2,
        RA_LOCKH = 3'd3,
        RA_SELL  = 3'd4,
        RA_SELH  = 3'd5,
        RA_DIRTY = 3'd6
    } reg_addr_e;

    localparam int CB_ERS  = 0;
    localparam int CB_EHV  = 1;
    localparam int CB_SHD  = 2;
    localparam int CB_DONE = 3;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/fes_regs.sv
// Module: fes_regs
// Holds the control, lock and select registers, decodes software writes,
// and produces the launch and abort pulses with the eligible-block mask.
// Assumes: NUM_LM, NUM_HI and NT do not exceed REG_W; running comes from the sequencer.
module fes_regs
    import fes_pkg::*;
#(
    parameter int NUM_LM = 8,
    parameter int NUM_HI = 4,
    parameter int NT     = NUM_LM + NUM_HI + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              running,
    input  logic              done,
    input  logic [NT-1:0]     dirty,
    output logic              ers_o,
    output logic              ehv_o,
    output logic [NUM_LM-1:0] lock_lm_o,
    output logic [NUM_HI-1:0] lock_hi_o,
    output logic [NUM_LM-1:0] sel_lm_o,
    output logic [NUM_HI-1:0] sel_hi_o,
    output logic              launch_o,
    output logic [NT-1:0]     launch_mask_o,
    output logic              abort_o
);
    localparam int NB = NUM_LM + NUM_HI;

    logic              ers_q, ehv_q, shd_q;
    logic [NUM_LM-1:0] locka_q, lockb_q, sell_q;
    logic [NUM_HI-1:0] lockh_q, selh_q;
    logic              wr_ctrl;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_ctrl      = reg_wr && (reg_addr == RA_CTRL);

    // Launch on an enable rise while erase mode is held and no run is active.
    assign launch_o = wr_ctrl && !running && ers_q && reg_wdata[CB_ERS]
                    && !ehv_q && reg_wdata[CB_EHV];
    // Abort when the enable bit is written low during a run.
    assign abort_o  = wr_ctrl && running && !reg_wdata[CB_EHV];

    // Eligible blocks: the shadow row alone, or the selected blocks that are not locked.
    always_comb begin
        if (reg_wdata[CB_SHD]) begin
            launch_mask_o = NT'(1) << NB;
        end else begin
            launch_mask_o = {1'b0, selh_q & ~lockh_q, sell_q & ~(locka_q | lockb_q)};
        end
    end

    // Control register: a run freezes everything except the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ers_q <= 1'b0;
            ehv_q <= 1'b0;
            shd_q <= 1'b0;
        end else if (wr_ctrl) begin
            if (running) begin
                ehv_q <= reg_wdata[CB_EHV];
            end else begin
                ers_q <= reg_wdata[CB_ERS];
                ehv_q <= reg_wdata[CB_EHV] & reg_wdata[CB_ERS] & ers_q;
                shd_q <= reg_wdata[CB_SHD];
            end
        end
    end

    // Lock registers: writable only while no run is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locka_q <= '0;
            lockb_q <= '0;
            lockh_q <= '0;
        end else if (reg_wr && !running) begin
            case (reg_addr)
                RA_LOCKA: locka_q <= reg_wdata[NUM_LM-1:0];
                RA_LOCKB: lockb_q <= reg_wdata[NUM_LM-1:0];
                RA_LOCKH: lockh_q <= reg_wdata[NUM_HI-1:0];
                default:  ;
            endcase
        end
    end

    // Select registers: cleared outside erase mode, frozen during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sell_q <= '0;
            selh_q <= '0;
        end else if (!ers_q) begin
            sell_q <= '0;
            selh_q <= '0;
        end else if (reg_wr && !running) begin
            case (reg_addr)
                RA_SELL: sell_q <= reg_wdata[NUM_LM-1:0];
                RA_SELH: selh_q <= reg_wdata[NUM_HI-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_ERS]  = ers_q;
                reg_rdata[CB_EHV]  = ehv_q;
                reg_rdata[CB_SHD]  = shd_q;
                reg_rdata[CB_DONE] = done;
            end
            RA_LOCKA: reg_rdata = REG_W'(locka_q);
            RA_LOCKB: reg_rdata = REG_W'(lockb_q);
            RA_LOCKH: reg_rdata = REG_W'(lockh_q);
            RA_SELL:  reg_rdata = REG_W'(sell_q);
            RA_SELH:  reg_rdata = REG_W'(selh_q);
            RA_DIRTY: reg_rdata = REG_W'(dirty);
            default:  reg_rdata = '0;
        endcase
    end

    assign ers_o     = ers_q;
    assign ehv_o     = ehv_q;
    assign lock_lm_o = locka_q | lockb_q;
    assign lock_hi_o = lockh_q;
    assign sel_lm_o  = sell_q;
    assign sel_hi_o  = selh_q;
endmodule

// File: rtl/fes_seq.sv
// Module: fes_seq
// Walks the pending-block mask from the lowest index upward, spending
// ERASE_CYC cycles per block, and reports the completion or abort of each block.
// Assumes: launch only arrives while idle; abort only arrives while running.
module fes_seq
    import fes_pkg::*;
#(
    parameter int NT        = 13,
    parameter int ERASE_CYC = 6,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ers_i,
    input  logic             launch_i,
    input  logic [NT-1:0]    launch_mask_i,
    input  logic             abort_i,
    output logic             running_o,
    output logic             done_o,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             erase_fire_o,
    output logic             abort_fire_o
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_CYC - 1);

    seq_state_e       state_q;
    logic [NT-1:0]    pend_q, cur_oh, pend_left;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] cur;
    logic             done_q, blk_end;

    // Lowest set bit of a mask: this sets the ascending erase order.
    function automatic logic [IDX_W-1:0] lowest_set(input logic [NT-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // Current block, its one-hot form and the blocks still to go after it.
    always_comb begin
        cur       = lowest_set(pend_q);
        cur_oh    = NT'(1) << cur;
        pend_left = pend_q & ~cur_oh;
        blk_end   = (state_q == SQ_RUN) && (cnt_q == CNT_LAST);
    end

    // Sequencer state, pending mask, per-block counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (launch_i) begin
                if (launch_mask_i != '0) begin
                    state_q <= SQ_RUN;
                    pend_q  <= launch_mask_i;
                    cnt_q   <= '0;
                    done_q  <= 1'b0;
                end else begin
                    done_q  <= 1'b1;
                end
            end else if (!ers_i) begin
                done_q <= 1'b0;
            end
        end else begin
            if (abort_i) begin
                state_q <= SQ_IDLE;
                pend_q  <= '0;
                cnt_q   <= '0;
                done_q  <= 1'b1;
            end else if (blk_end) begin
                pend_q <= pend_left;
                cnt_q  <= '0;
                if (pend_left == '0) begin
                    state_q <= SQ_IDLE;
                    done_q  <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign running_o    = (state_q == SQ_RUN);
    assign done_o       = done_q;
    assign cur_idx_o    = cur;
    assign erase_fire_o = blk_end && !abort_i;
    assign abort_fire_o = (state_q == SQ_RUN) && abort_i;
endmodule

// File: rtl/fes_array.sv
// Module: fes_array
// Register-file model of the flash array: one row per block plus the shadow row.
// A completed erase writes all ones; an abort writes ABORT_WORD and sets the dirty flag.
// Assumes: idx_i is below NT whenever a fire strobe is high.
module fes_array #(
    parameter int              NT         = 13,
    parameter int              WORDS      = 4,
    parameter int              DW         = 32,
    parameter int              IDX_W      = 4,
    parameter int              WA_W       = 2,
    parameter logic [DW-1:0]   ABORT_WORD = 32'hA5C3_5A3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase_fire_i,
    input  logic             abort_fire_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] rd_blk_i,
    input  logic [WA_W-1:0]  rd_word_i,
    output logic [DW-1:0]    rd_data_o,
    output logic [NT-1:0]    dirty_o
);
    logic [DW-1:0] mem_q [NT][WORDS];
    logic [NT-1:0] dirty_q;

    // Array contents: cleared on reset, filled by erase completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NT; b++) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem_q[b][w] <= '0;
                end
            end
        end else if (erase_fire_i) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[idx_i][w] <= '1;
            end
        end else if (abort_fire_i) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[idx_i][w] <= ABORT_WORD;
            end
        end
    end

    // Dirty flags: set by an abort, cleared by a later completed erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (erase_fire_i) begin
            dirty_q[idx_i] <= 1'b0;
        end else if (abort_fire_i) begin
            dirty_q[idx_i] <= 1'b1;
        end
    end

    // Read port; out-of-range block indices read zero.
    always_comb begin
        if (rd_blk_i < IDX_W'(NT)) begin
            rd_data_o = mem_q[rd_blk_i][rd_word_i];
        end else begin
            rd_data_o = '0;
        end
    end

    assign dirty_o = dirty_q;
endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq
// Top level of the multi-block erase sequencer: register file, sequencer and array model.
// Assumes: a single clock, synchronous active-low reset, NUM_LM and NUM_HI of at most 31 in total.
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int            NUM_LM     = 8,
    parameter int            NUM_HI     = 4,
    parameter int            WORDS      = 4,
    parameter int            DW         = 32,
    parameter int            ERASE_CYC  = 6,
    parameter logic [DW-1:0] ABORT_WORD = 32'hA5C3_5A3C,
    localparam int           NB         = NUM_LM + NUM_HI,
    localparam int           NT         = NB + 1,
    localparam int           IDX_W      = $clog2(NT),
    localparam int           WA_W       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0] rd_blk,
    input  logic [WA_W-1:0]  rd_word,
    output logic [DW-1:0]    rd_data
);
    logic              running, done, ers, ehv, launch, abort;
    logic              erase_fire, abort_fire;
    logic [NT-1:0]     launch_mask, dirty;
    logic [IDX_W-1:0]  cur_idx;
    logic [NUM_LM-1:0] lock_lm, sel_lm;
    logic [NUM_HI-1:0] lock_hi, sel_hi;

    fes_regs #(
        .NUM_LM(NUM_LM), .NUM_HI(NUM_HI), .NT(NT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .running(running), .done(done), .dirty(dirty),
        .ers_o(ers), .ehv_o(ehv),
        .lock_lm_o(lock_lm), .lock_hi_o(lock_hi), .sel_lm_o(sel_lm), .sel_hi_o(sel_hi),
        .launch_o(launch), .launch_mask_o(launch_mask), .abort_o(abort)
    );

    fes_seq #(
        .NT(NT), .ERASE_CYC(ERASE_CYC), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ers_i(ers), .launch_i(launch), .launch_mask_i(launch_mask), .abort_i(abort),
        .running_o(running), .done_o(done), .cur_idx_o(cur_idx),
        .erase_fire_o(erase_fire), .abort_fire_o(abort_fire)
    );

    fes_array #(
        .NT(NT), .WORDS(WORDS), .DW(DW), .IDX_W(IDX_W), .WA_W(WA_W), .ABORT_WORD(ABORT_WORD)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .erase_fire_i(erase_fire), .abort_fire_i(abort_fire), .idx_i(cur_idx),
        .rd_blk_i(rd_blk), .rd_word_i(rd_word), .rd_data_o(rd_data), .dirty_o(dirty)
    );
endmodule

// File: rtl/fes_checker.sv
// Module: fes_checker
// Protocol and ordering properties of the erase sequencer, bound to flash_erase_seq.
module fes_checker #(
    parameter int NUM_LM = 8,
    parameter int NUM_HI = 4,
    parameter int NT     = 13,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              done,
    input logic              ers,
    input logic              ehv,
    input logic              launch,
    input logic [NT-1:0]     launch_mask,
    input logic              erase_fire,
    input logic              abort_fire,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [NUM_LM-1:0] lock_lm,
    input logic [NUM_HI-1:0] lock_hi,
    input logic [NUM_LM-1:0] sel_lm,
    input logic [NUM_HI-1:0] sel_hi
);
    logic [NT-1:0] lock_ext;
    assign lock_ext = {1'b0, lock_hi, lock_lm};

    AST_LOCKED_NOT_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fire |-> !lock_ext[cur_idx]);                                   // R3
    AST_ASCENDING_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fire |=> (!running || (cur_idx > $past(cur_idx))));             // R4
    AST_EHV_NEEDS_ERS: assert property (@(posedge clk) disable iff (!rst_n)
        !ers |-> !ehv);                                                       // R5
    AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_fire |=> (done && !running));                                   // R7
    AST_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(lock_lm) && $stable(lock_hi)
                                       && $stable(sel_lm) && $stable(sel_hi))); // R9
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (launch_mask == '0)) |=> (done && !running));             // R10
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ers |=> !done);                                                      // R11
endmodule

bind flash_erase_seq fes_checker #(
    .NUM_LM(NUM_LM), .NUM_HI(NUM_HI), .NT(NT), .IDX_W(IDX_W)
) u_fes_checker (
    .clk(clk), .rst_n(rst_n), .running(running), .done(done), .ers(ers), .ehv(ehv),
    .launch(launch), .launch_mask(launch_mask), .erase_fire(erase_fire),
    .abort_fire(abort_fire), .cur_idx(cur_idx), .lock_lm(lock_lm), .lock_hi(lock_hi),
    .sel_lm(sel_lm), .sel_hi(sel_hi)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
    import fes_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_LM = 8;
    localparam int NUM_HI = 4;
    localparam int WORDS = 4;
    localparam int DW = 32;
    localparam int ERASE_CYC = 6;
    localparam logic [31:0] ABORT_WORD = 32'hA5C3_5A3C;
    localparam int NB = NUM_LM + NUM_HI;
    localparam int NT = NB + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  rd_blk = '0;
    logic [1:0]  rd_word = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int st [NT];               // 0 = zero, 1 = erased, 2 = abort pattern
    logic [NT-1:0] dty = '0;
    logic [NUM_LM-1:0] la = '0, lb = '0;
    logic [NUM_HI-1:0] lh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq #(
        .NUM_LM(NUM_LM), .NUM_HI(NUM_HI), .WORDS(WORDS), .DW(DW),
        .ERASE_CYC(ERASE_CYC), .ABORT_WORD(ABORT_WORD)
    ) i_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_blk(rd_blk), .rd_word(rd_word), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] word_of(input int s);
        if (s == 1) return '1;
        if (s == 2) return ABORT_WORD;
        return '0;
    endfunction

    function automatic logic [NT-1:0] elig(input logic [NUM_LM-1:0] sl, input logic [NUM_HI-1:0] sh, input bit shd);
        if (shd) return NT'(1) << NB;
        return {1'b0, sh & ~lh, sl & ~(la | lb)};
    endfunction

    task automatic check_array(input string req);
        logic [31:0] v;
        for (int b = 0; b < NT; b++) begin
            bit ok = 1;
            logic [31:0] bad = '0;
            @(negedge clk);
            rd_blk = 4'(b);
            for (int w = 0; w < WORDS; w++) begin
                rd_word = 2'(w);
                #1;
                if (rd_data !== word_of(st[b])) begin ok = 0; bad = rd_data; end
            end
            chk(ok, $sformatf("%s block %0d contents", req, b), bad, word_of(st[b]));
        end
        rd(RA_DIRTY, v);
        chk(v == 32'(dty), {req, " dirty flags"}, v, 32'(dty));
    endtask

    task automatic set_locks(input logic [NUM_LM-1:0] a, input logic [NUM_LM-1:0] b, input logic [NUM_HI-1:0] h);
        la = a; lb = b; lh = h;
        wr(RA_LOCKA, 32'(a)); wr(RA_LOCKB, 32'(b)); wr(RA_LOCKH, 32'(h));
    endtask

    // One erase run; abort_d = 0 runs to completion, else the abort write lands abort_d cycles after launch.
    task automatic run(input logic [NUM_LM-1:0] sl, input logic [NUM_HI-1:0] sh, input bit shd,
                       input int abort_d, input string req);
        logic [NT-1:0] m;
        logic [31:0] v;
        int k, j, n, cyc;
        wr(RA_CTRL, 32'h1);
        wr(RA_SELL, 32'(sl));
        wr(RA_SELH, 32'(sh));
        m = elig(sl, sh, shd);
        k = $countones(m);
        wr(RA_CTRL, 32'h3 | (32'(shd) << CB_SHD));
        if (abort_d == 0) begin
            reg_addr = RA_CTRL;
            #1 cyc = 0;
            while (!reg_rdata[CB_DONE] && cyc < 5000) begin
                @(posedge clk); cyc++;
                @(negedge clk); #1;
            end
            chk(cyc == k * ERASE_CYC, {req, " R4 done latency"}, 32'(cyc), 32'(k * ERASE_CYC));
            j = k;
        end else begin
            repeat (abort_d - 2) @(negedge clk);
            wr(RA_CTRL, 32'h1 | (32'(shd) << CB_SHD));
            rd(RA_CTRL, v);
            chk(v[CB_DONE] == 1'b1, {req, " R7 done after abort"}, v, 32'h9);
            j = (abort_d - 1) / ERASE_CYC;
        end
        n = 0;
        for (int b = 0; b < NT; b++) begin
            if (m[b]) begin
                if (n < j) begin st[b] = 1; dty[b] = 1'b0; end
                else if (n == j) begin st[b] = 2; dty[b] = 1'b1; end
                n++;
            end
        end
        check_array(req);
        wr(RA_CTRL, 32'h0);
        rd(RA_CTRL, v);
        chk(v[CB_DONE] == 1'b0, "R11 done cleared", v, 32'h0);
        rd(RA_SELL, v);
        chk(v == 32'h0, "R11 select cleared", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NT; b++) st[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, $sformatf("R1 register %0d after reset", a), v, 32'h0);
        end
        check_array("R1");

        // R12: lock read-back
        set_locks(8'h01, 8'h04, 4'h2);
        rd(RA_LOCKA, v); chk(v == 32'h01, "R12 lock A", v, 32'h01);
        rd(RA_LOCKB, v); chk(v == 32'h04, "R12 lock B", v, 32'h04);
        rd(RA_LOCKH, v); chk(v == 32'h02, "R12 high lock", v, 32'h02);

        // R3/R2: everything selected, blocks 0, 2 and 9 locked
        run(8'hFF, 4'hF, 1'b0, 0, "R3 R2");

        // R5: enable refused without erase mode; selects ignored with erase mode low
        set_locks('0, '0, '0);
        wr(RA_CTRL, 32'h2);
        rd(RA_CTRL, v); chk(v == 32'h0, "R5 enable without erase mode", v, 32'h0);
        wr(RA_SELL, 32'hFF);
        rd(RA_SELL, v); chk(v == 32'h0, "R5 select while erase mode low", v, 32'h0);
        check_array("R5");

        // R10: no eligible block
        run('0, '0, 1'b0, 0, "R10");

        // R6: shadow row only, selects ignored
        run(8'h05, 4'h2, 1'b1, 0, "R6");

        // R7: abort in the second block (blocks 0, 2, 9 selected)
        run(8'h05, 4'h2, 1'b0, ERASE_CYC + 2, "R7");

        // R9/R8: writes during a run are ignored; dirty block 2 is erased clean
        wr(RA_CTRL, 32'h1);
        wr(RA_SELL, 32'h04);
        wr(RA_SELH, 32'h2);
        wr(RA_CTRL, 32'h3);
        wr(RA_LOCKA, 32'hFF);
        wr(RA_SELL, 32'h0);
        wr(RA_CTRL, 32'h2);
        rd(RA_LOCKA, v); chk(v == 32'h0, "R9 lock write during run", v, 32'h0);
        rd(RA_SELL, v); chk(v == 32'h04, "R9 select write during run", v, 32'h04);
        rd(RA_CTRL, v); chk(v[CB_ERS] == 1'b1, "R9 erase mode held during run", v, 32'h3);
        reg_addr = RA_CTRL;
        for (int t = 0; t < 200 && !reg_rdata[CB_DONE]; t++) begin
            @(negedge clk); #1;
        end
        st[2] = 1; st[9] = 1; dty[2] = 1'b0;
        check_array("R8 R9");
        wr(RA_CTRL, 32'h0);

        // Random mix of locks, selects and aborts (R2 R3 R4 R7)
        for (int it = 0; it < 10; it++) begin
            logic [NUM_LM-1:0] sl;
            logic [NUM_HI-1:0] sh;
            int k, d;
            bit shd;
            set_locks(NUM_LM'($urandom) & NUM_LM'($urandom), NUM_LM'($urandom) & NUM_LM'($urandom),
                      NUM_HI'($urandom) & NUM_HI'($urandom));
            sl = NUM_LM'($urandom);
            sh = NUM_HI'($urandom);
            shd = ($urandom % 6) == 0;
            k = $countones(elig(sl, sh, shd));
            d = 0;
            if (k > 0 && ($urandom % 2) == 0) d = 2 + int'($urandom % (k * ERASE_CYC));
            run(sl, sh, shd, d, $sformatf("R2 R3 R7 random %0d", it));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule